// File: doc/BRIEF.md
# Low-Power Mode Entry Controller

This block decides which low-power state the system takes when the processor asks for deep sleep. A mode-select bit in a small configuration register chooses between Stop and Standby. On entry, the block sets a sticky flag that records the state reached. While in Stop, it drives two control outputs: the core-voltage scale applied during Stop, and a request that puts the flash into its low-power mode. A wake-event pulse returns the block to Run and releases both outputs.

The two flags respond to different reset classes. The Stop flag clears on either the power-on reset or the system reset. The Standby flag clears only on the power-on reset, so software can still see it after the system reset that normally follows a Standby exit. Both flags also clear through a single self-clearing command bit in the configuration register. Choosing the lowest stop-voltage scale always forces the flash low-power request, whatever the flash bit holds.

Top module: `lpm_entry_ctrl`

## Requirements
- R1: When `sleepReq` is sampled high in Run, `lpState` changes at that clock edge. It goes to Stop (code 1) when the mode bit (config bit 0) is 0, and to Standby (code 2) when it is 1. Run is code 0.
- R2: `flagStop` is set at the edge where Stop is entered. It is cleared by the power-on reset, by the system reset, or by the clear command.
- R3: `flagStandby` is set at the edge where Standby is entered. It is cleared only by the power-on reset or by the clear command. A system reset leaves it unchanged.
- R4: Config bit 4 is the clear command. Writing it as 1 clears both flags at that edge. The bit is not stored and always reads 0.
- R5: The stop-voltage scale field is config bits 2:1. Its reset value is 3, and the config reads back 5'b00110 after reset.
- R6: Config bit 3 is the flash low-power bit. While in Stop, `flashLpReq` equals the value the bit held at entry. Outside Stop, `flashLpReq` is 0.
- R7: If Stop is entered with scale value 1 selected, `flashLpReq` is 1 throughout Stop, even when the flash bit is 0.
- R8: A write with scale value 0 leaves the scale field unchanged. The other fields of that write still take effect.
- R9: A wake-event pulse in Stop or Standby returns `lpState` to Run at that edge. At the same edge, `flashLpReq` drops to 0 and `stopVoltLvl` drops to 0. While in Stop, `stopVoltLvl` shows the scale captured at entry.
- R10: If a flag-set event and the clear command arrive in the same cycle, the flag ends up set.
- R11: `sleepReq` has no effect outside Run, and `wakeEvt` has no effect in Run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, active low, asynchronous |
| sysRstN | input | 1 | System reset, active low, asynchronous |
| sleepReq | input | 1 | Deep-sleep request from the processor |
| wakeEvt | input | 1 | Wake-event pulse |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 5 | Write data: bit0 mode, bits2:1 scale, bit3 flash, bit4 clear |
| cfgRdData | output | 5 | Configuration readback; bit 4 always 0 |
| lpState | output | 2 | 0 Run, 1 Stop, 2 Standby |
| flagStop | output | 1 | Sticky Stop-entered flag |
| flagStandby | output | 1 | Sticky Standby-entered flag |
| flashLpReq | output | 1 | Flash low-power request |
| stopVoltLvl | output | 2 | Applied stop-voltage scale; 0 outside Stop |

## Verification
Two things can land on the same clock edge: a state entry that sets a flag, and a configuration write that carries the clear command. The bench drives `sleepReq` and a write with bit 4 set on the same clock edge. After that edge it expects the entry's flag to read 1 and the configuration to read back without the clear bit. A second case clears the flags on its own and expects both to read 0, so the two cases together show that set takes priority rather than the clear being lost.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int SCALE_W = 2;
  localparam int CFG_W = 5;
  localparam int MODE_BIT = 0;
  localparam int SCALE_LSB = 1;
  localparam int FLASH_BIT = 3;
  localparam int CLR_BIT = 4;
  localparam logic [SCALE_W-1:0] SCALE_RESET = 2'd3;
  localparam logic [SCALE_W-1:0] SCALE_LOWEST = 2'd1;
  localparam logic [SCALE_W-1:0] SCALE_NONE = 2'd0;

  typedef enum logic [1:0] {
    LPM_RUN     = 2'd0,
    LPM_STOP    = 2'd1,
    LPM_STANDBY = 2'd2
  } lpm_state_t;

  typedef struct packed {
    logic enterStop;
    logic enterStandby;
    logic wakeUp;
  } lpm_strobe_t;
endpackage

// File: rtl/lpm_ctrl_fsm.sv
module lpm_ctrl_fsm
  import lpm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sleepReq,
  input  logic        wakeEvt,
  input  logic        modeSel,
  output lpm_state_t  state,
  output lpm_strobe_t strobe
);
  lpm_state_t nextState;

  always_comb begin
    strobe = '0;
    nextState = state;
    unique case (state)
      LPM_RUN: begin
        if (sleepReq) begin
          if (modeSel) begin
            nextState = LPM_STANDBY;
            strobe.enterStandby = 1'b1;
          end else begin
            nextState = LPM_STOP;
            strobe.enterStop = 1'b1;
          end
        end
      end
      LPM_STOP, LPM_STANDBY: begin
        if (wakeEvt) begin
          nextState = LPM_RUN;
          strobe.wakeUp = 1'b1;
        end
      end
      default: nextState = LPM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= LPM_RUN;
    else       state <= nextState;
  end

  AST_WAKE_TO_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (state != LPM_RUN && wakeEvt) |=> state == LPM_RUN); // R9
  AST_SLEEP_HELD_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (state == LPM_STANDBY && sleepReq && !wakeEvt) |=> state == LPM_STANDBY); // R11
  AST_RUN_WAKE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (state == LPM_RUN && !sleepReq) |=> state == LPM_RUN); // R11
  AST_ENTRY_BY_MODE: assert property (@(posedge clk) disable iff (!rstN)
    (state == LPM_RUN && sleepReq) |=> state == (modeSel ? LPM_STANDBY : LPM_STOP)); // R1
endmodule

// File: rtl/lpm_datapath.sv
module lpm_datapath
  import lpm_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               porRstN,
  input  lpm_strobe_t        strobe,
  input  logic               cfgWrEn,
  input  logic [CFG_W-1:0]   cfgWrData,
  output logic               modeSel,
  output logic [CFG_W-1:0]   cfgRdData,
  output logic               flagStop,
  output logic               flagStandby,
  output logic               flashLpReq,
  output logic [SCALE_W-1:0] stopVoltLvl
);
  logic               flashBit;
  logic [SCALE_W-1:0] scaleSel;
  logic [SCALE_W-1:0] wrScale;
  logic               clearCmd;

  assign wrScale  = cfgWrData[SCALE_LSB +: SCALE_W];
  assign clearCmd = cfgWrEn && cfgWrData[CLR_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeSel  <= 1'b0;
      flashBit <= 1'b0;
      scaleSel <= SCALE_RESET;
    end else if (cfgWrEn) begin
      modeSel  <= cfgWrData[MODE_BIT];
      flashBit <= cfgWrData[FLASH_BIT];
      if (wrScale != SCALE_NONE) scaleSel <= wrScale;
    end
  end

  always_comb begin
    cfgRdData = '0;
    cfgRdData[MODE_BIT] = modeSel;
    cfgRdData[FLASH_BIT] = flashBit;
    cfgRdData[SCALE_LSB +: SCALE_W] = scaleSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   flagStop <= 1'b0;
    else if (strobe.enterStop)   flagStop <= 1'b1;
    else if (clearCmd)           flagStop <= 1'b0;
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)                 flagStandby <= 1'b0;
    else if (strobe.enterStandby) flagStandby <= 1'b1;
    else if (clearCmd)            flagStandby <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flashLpReq  <= 1'b0;
      stopVoltLvl <= SCALE_NONE;
    end else if (strobe.enterStop) begin
      flashLpReq  <= flashBit || (scaleSel == SCALE_LOWEST);
      stopVoltLvl <= scaleSel;
    end else if (strobe.wakeUp) begin
      flashLpReq  <= 1'b0;
      stopVoltLvl <= SCALE_NONE;
    end
  end

  AST_STOP_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    strobe.enterStop |=> flagStop); // R2
  AST_STBY_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    strobe.enterStandby |=> flagStandby); // R3
  AST_CLEAR_ACTS: assert property (@(posedge clk) disable iff (!rstN)
    (clearCmd && !strobe.enterStop) |=> !flagStop); // R4
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (clearCmd && strobe.enterStop) |=> flagStop); // R10
  AST_LOWEST_FORCES_FLASH: assert property (@(posedge clk) disable iff (!rstN)
    (stopVoltLvl == SCALE_LOWEST) |-> flashLpReq); // R7
  AST_SCALE_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    scaleSel != SCALE_NONE); // R8
  AST_WAKE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wakeUp |=> (!flashLpReq && stopVoltLvl == SCALE_NONE)); // R9
endmodule

// File: rtl/lpm_entry_ctrl.sv
module lpm_entry_ctrl
  import lpm_pkg::*;
(
  input  logic               clk,
  input  logic               porRstN,
  input  logic               sysRstN,
  input  logic               sleepReq,
  input  logic               wakeEvt,
  input  logic               cfgWrEn,
  input  logic [CFG_W-1:0]   cfgWrData,
  output logic [CFG_W-1:0]   cfgRdData,
  output logic [1:0]         lpState,
  output logic               flagStop,
  output logic               flagStandby,
  output logic               flashLpReq,
  output logic [SCALE_W-1:0] stopVoltLvl
);
  logic        rstN;
  logic        modeSel;
  lpm_state_t  state;
  lpm_strobe_t strobe;

  assign rstN    = porRstN && sysRstN;
  assign lpState = state;

  lpm_ctrl_fsm u_fsm (
    .clk      (clk),
    .rstN     (rstN),
    .sleepReq (sleepReq),
    .wakeEvt  (wakeEvt),
    .modeSel  (modeSel),
    .state    (state),
    .strobe   (strobe)
  );

  lpm_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .porRstN     (porRstN),
    .strobe      (strobe),
    .cfgWrEn     (cfgWrEn),
    .cfgWrData   (cfgWrData),
    .modeSel     (modeSel),
    .cfgRdData   (cfgRdData),
    .flagStop    (flagStop),
    .flagStandby (flagStandby),
    .flashLpReq  (flashLpReq),
    .stopVoltLvl (stopVoltLvl)
  );

  AST_FLASH_ONLY_IN_STOP: assert property (@(posedge clk) disable iff (!rstN)
    flashLpReq |-> state == LPM_STOP); // R6
endmodule

// File: tb/lpm_entry_ctrl_tb.sv
module lpm_entry_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       porRstN = 1'b0;
  logic       sysRstN = 1'b0;
  logic       sleepReq = 1'b0;
  logic       wakeEvt = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [4:0] cfgWrData = '0;
  logic [4:0] cfgRdData;
  logic [1:0] lpState;
  logic       flagStop, flagStandby, flashLpReq;
  logic [1:0] stopVoltLvl;

  int nChecks = 0;
  int nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpm_entry_ctrl dut_i (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN),
    .sleepReq(sleepReq), .wakeEvt(wakeEvt),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .lpState(lpState), .flagStop(flagStop), .flagStandby(flagStandby),
    .flashLpReq(flashLpReq), .stopVoltLvl(stopVoltLvl)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [4:0] d);
    @(negedge clk); cfgWrEn = 1'b1; cfgWrData = d;
    @(negedge clk); cfgWrEn = 1'b0; cfgWrData = '0;
  endtask

  task automatic pulseSleep();
    @(negedge clk); sleepReq = 1'b1;
    @(negedge clk); sleepReq = 1'b0;
  endtask

  task automatic pulseWake();
    @(negedge clk); wakeEvt = 1'b1;
    @(negedge clk); wakeEvt = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 reset state run", lpState, 0);
    chk("R2 reset stop flag", flagStop, 0);
    chk("R3 reset standby flag", flagStandby, 0);
    chk("R5 reset config", cfgRdData, 6);
    chk("R6 reset flash req", flashLpReq, 0);
    chk("R9 reset volt", stopVoltLvl, 0);
  endtask

  task automatic testStopNormal();
    cfgWrite(5'h06);
    pulseSleep();
    chk("R1 stop entered", lpState, 1);
    chk("R2 stop flag set", flagStop, 1);
    chk("R6 flash normal in stop", flashLpReq, 0);
    chk("R9 stop volt applied", stopVoltLvl, 3);
    pulseWake();
    chk("R9 back to run", lpState, 0);
    chk("R9 volt released", stopVoltLvl, 0);
    chk("R2 flag sticky after wake", flagStop, 1);
  endtask

  task automatic testClear();
    cfgWrite(5'h16);
    chk("R4 clear stop flag", flagStop, 0);
    chk("R4 clear bit reads 0", cfgRdData, 6);
  endtask

  task automatic testFlashBit();
    cfgWrite(5'h0E);
    pulseSleep();
    chk("R6 flash low power in stop", flashLpReq, 1);
    pulseWake();
    chk("R9 flash released", flashLpReq, 0);
  endtask

  task automatic testLowestScale();
    cfgWrite(5'h02);
    chk("R5 scale readback", cfgRdData, 2);
    pulseSleep();
    chk("R7 forced flash", flashLpReq, 1);
    chk("R7 volt lowest", stopVoltLvl, 1);
    pulseWake();
    chk("R9 forced flash released", flashLpReq, 0);
  endtask

  task automatic testReservedScale();
    cfgWrite(5'h04);
    cfgWrite(5'h08);
    chk("R8 zero scale ignored", cfgRdData, 5'h0C);
  endtask

  task automatic testStandby();
    cfgWrite(5'h05);
    pulseSleep();
    chk("R1 standby entered", lpState, 2);
    chk("R3 standby flag set", flagStandby, 1);
    chk("R6 no flash in standby", flashLpReq, 0);
    chk("R9 no volt in standby", stopVoltLvl, 0);
    pulseSleep();
    chk("R11 sleep ignored in standby", lpState, 2);
    pulseWake();
    chk("R9 wake from standby", lpState, 0);
  endtask

  task automatic testWakeInRun();
    pulseWake();
    chk("R11 wake ignored in run", lpState, 0);
    chk("R11 standby flag kept", flagStandby, 1);
  endtask

  task automatic testSysReset();
    cfgWrite(5'h04);
    pulseSleep();
    chk("R2 stop flag before sys reset", flagStop, 1);
    @(negedge clk); sysRstN = 1'b0;
    @(negedge clk); sysRstN = 1'b1;
    chk("R2 sys reset clears stop flag", flagStop, 0);
    chk("R3 sys reset keeps standby flag", flagStandby, 1);
    chk("R1 sys reset to run", lpState, 0);
    chk("R5 sys reset config", cfgRdData, 6);
  endtask

  task automatic testPor();
    @(negedge clk); porRstN = 1'b0;
    @(negedge clk); porRstN = 1'b1;
    chk("R3 por clears standby flag", flagStandby, 0);
  endtask

  task automatic testSetWins();
    cfgWrite(5'h06);
    @(negedge clk); sleepReq = 1'b1; cfgWrEn = 1'b1; cfgWrData = 5'h16;
    @(negedge clk); sleepReq = 1'b0; cfgWrEn = 1'b0; cfgWrData = '0;
    chk("R10 set beats clear", flagStop, 1);
    chk("R1 entered during clear", lpState, 1);
    pulseWake();
    cfgWrite(5'h16);
    chk("R4 later clear works", flagStop, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    porRstN = 1'b1; sysRstN = 1'b1;
    testReset();
    testStopNormal();
    testClear();
    testFlashBit();
    testLowestScale();
    testReservedScale();
    testStandby();
    testWakeInRun();
    testSysReset();
    testPor();
    testSetWins();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule